// File: doc/BRIEF.md
# Multi-User Inter-Processor Mailbox

This block lets several processors exchange 32-bit messages through a set of small hardware queues. A sender writes a word to a queue's message register. A receiver reads that same register to take the oldest word. For each queue, the block also exposes a full flag and an occupancy count. All access goes through a simple register bus that completes in one cycle. The read data is combinational, and a read or write takes effect at the clock edge that ends the access cycle.

Each user (one per processor) has three registers: a sticky event-status register, an enable register, and an interrupt line. Every queue contributes two events to each user's status:

- **New-message event:** a word arrived, or words are still waiting.
- **Not-full event:** the queue has room.

Software clears a status bit by writing 1 to it. The enable register is written through two separate addresses: one sets bits and the other clears them. A user can therefore mask or unmask a single source without a read-modify-write.

Queue count, user count and queue depth are parameters. The defaults are four queues, two users and a depth of four words.

Top module: `mbox_hub`

## Requirements
- R1: Address 0x000 reads a fixed identification value (default 0x4D420100). Writes to it have no effect.
- R2: Writing address 0x040+4*m appends the word to queue m. Reading the same address returns and removes the oldest word, so words come out in first-in first-out order.
- R3: Address 0x080+4*m reads 1 while queue m holds depth words, and 0 otherwise.
- R4: Address 0x0C0+4*m reads the number of words held in queue m. Zero means empty.
- R5: A write to a full queue is dropped, and the queue contents and count are unchanged. A read from an empty queue returns 0 and leaves the count at 0.
- R6: User u's status register is at 0x104+0x10*u. In it, bit 2*m is the new-message event of queue m and bit 2*m+1 is the not-full event of queue m. Every user sees every queue's events.
- R7: A new-message bit is set by an accepted write and is re-set on every cycle in which the queue is non-empty. After a clear while words remain, it reads 0 for exactly one cycle and then reads 1 again. If the queue is empty, it stays at 0.
- R8: A not-full bit is set in every cycle in which the queue holds fewer than depth words, and by any accepted read. It stays at 0 after a clear while the queue is full.
- R9: Writing status with 1 in a bit position clears that bit. Bits written with 0 keep their value. Clearing one user's status leaves the other users' status unchanged.
- R10: Writing 0x108+0x10*u ORs the written ones into user u's enables. Writing 0x10C+0x10*u clears the enables at the written ones. Reading either address returns the enables.
- R11: User u's interrupt output is high exactly when some bit is set in both its status and its enables. Each user's line is independent of the others.
- R12: While reset is asserted, every queue count, status bit, enable bit and interrupt output is 0. Reset asserts asynchronously and is released on the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (9) | Byte address of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, valid in the access cycle |
| irq | output | NU (2) | One interrupt line per user |

## Verification
The hardest behaviour to reach is the one-cycle gap in the interrupt-status bits: a cleared bit is re-armed on the next cycle, either because words remain in the queue or because a read has just made room in a full queue.

To reach these cases, the stimulus first fills a queue to its depth, pushes one more word that must be dropped, and clears the not-full bit. It then reads the status register on back-to-back cycles around a pop. The same back-to-back reads are used after clearing a new-message bit while a word is still queued.

The interrupt lines are checked on the cycle right after such a clear, and after enables are set and cleared for one user while the other user's enables are left unchanged.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Base offsets of the register groups; per-queue and per-user strides follow.
  localparam int unsigned OFS_ID       = 32'h000;
  localparam int unsigned OFS_MSG      = 32'h040;
  localparam int unsigned OFS_FULL     = 32'h080;
  localparam int unsigned OFS_CNT      = 32'h0C0;
  localparam int unsigned OFS_USR_STAT = 32'h104;
  localparam int unsigned OFS_USR_ESET = 32'h108;
  localparam int unsigned OFS_USR_ECLR = 32'h10C;
  localparam int unsigned Q_STRIDE     = 4;
  localparam int unsigned U_STRIDE     = 16;

  // Accepted queue actions, used to raise events in the same cycle.
  typedef struct packed {
    logic push_ok;
    logic pop_ok;
  } q_act_t;

endpackage

// File: rtl/mbox_queue.sv
module mbox_queue #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [DW-1:0]                wdata,
  input  logic                         pop,
  output logic [DW-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty,
  output mbox_pkg::q_act_t             act
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok, ptr_en;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign ptr_en  = push_ok | pop_ok;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push_ok) begin
      wr_ptr_d = wrap_inc(wr_ptr_q);
      cnt_d    = cnt_q + CW'(1);
    end
    if (pop_ok) begin
      rd_ptr_d = wrap_inc(rd_ptr_q);
      cnt_d    = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (ptr_en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // Storage holds no reset: contents are qualified by the count.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= wdata;
  end

  assign head        = empty ? '0 : mem[rd_ptr_q];
  assign count       = cnt_q;
  assign act.push_ok = push_ok;
  assign act.pop_ok  = pop_ok;

  // R5: occupancy never exceeds the depth.
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R5: a write to a full queue leaves the count unchanged.
  a_r5_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt_q == CW'(DEPTH)));

  // R5: a read of an empty queue leaves it empty.
  a_r5_empty_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (cnt_q == '0));

  // R2: a read with data present removes exactly one word.
  a_r2_pop_removes_one: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/mbox_user_irq.sv
module mbox_user_irq #(
  parameter int NB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] evt,
  input  logic          stat_we,
  input  logic          eset_we,
  input  logic          eclr_we,
  input  logic [NB-1:0] wdata,
  output logic [NB-1:0] status,
  output logic [NB-1:0] enable,
  output logic          irq
);
  logic [NB-1:0] st_q, st_d, en_q, en_d, clr_mask;
  logic          st_upd, en_upd;

  // Clearing wins within its own cycle; a standing event re-arms next cycle.
  assign clr_mask = stat_we ? wdata : '0;
  assign st_d     = (st_q | evt) & ~clr_mask;
  assign st_upd   = stat_we | (|(evt & ~st_q));

  always_comb begin
    en_d = en_q;
    if (eset_we)      en_d = en_q | wdata;
    else if (eclr_we) en_d = en_q & ~wdata;
  end
  assign en_upd = eset_we | eclr_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= '0;
    else if (st_upd) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (en_upd) en_q <= en_d;
  end

  assign status = st_q;
  assign enable = en_q;
  assign irq    = |(st_q & en_q);

  // R9: without a status write no set bit is lost.
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_we |=> ((st_q & $past(st_q)) == $past(st_q)));

  // R9: written ones are clear right after the write.
  a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> ((st_q & $past(wdata)) == '0));

  // R7 and R8: an event outside a clear lands in status.
  a_r7_event_captured: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_we |=> ((st_q & $past(evt)) == $past(evt)));

  // R10: set and clear of the enables.
  a_r10_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    eset_we |=> ((en_q & $past(wdata)) == $past(wdata)));
  a_r10_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (eclr_we && !eset_we) |=> ((en_q & $past(wdata)) == '0));

  // R11: an interrupt needs both a pending event and an enable.
  a_r11_irq_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((|st_q) && (|en_q)));
endmodule

// File: rtl/mbox_hub.sv
module mbox_hub #(
  parameter int          NQ    = 4,
  parameter int          NU    = 2,
  parameter int          DEPTH = 4,
  parameter int          DW    = 32,
  parameter int          AW    = 9,
  parameter logic [31:0] ID    = 32'h4D42_0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [NU-1:0] irq
);
  import mbox_pkg::*;

  localparam int NB = 2 * NQ;
  localparam int CW = $clog2(DEPTH+1);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic wr_req, rd_req;
  assign wr_req = bus_sel & bus_wr;
  assign rd_req = bus_sel & ~bus_wr;

  logic          hit_id;
  logic [NQ-1:0] hit_msg, hit_full, hit_cnt;
  logic [NU-1:0] hit_stat, hit_eset, hit_eclr;

  assign hit_id = (bus_addr == AW'(OFS_ID));

  logic [NQ-1:0] q_full, q_empty, q_push, q_pop;
  logic [DW-1:0] q_head [NQ];
  logic [CW-1:0] q_cnt  [NQ];
  q_act_t        q_act  [NQ];
  logic [NB-1:0] evt;

  for (genvar m = 0; m < NQ; m++) begin : g_queue
    assign hit_msg[m]  = (bus_addr == AW'(OFS_MSG  + Q_STRIDE * m));
    assign hit_full[m] = (bus_addr == AW'(OFS_FULL + Q_STRIDE * m));
    assign hit_cnt[m]  = (bus_addr == AW'(OFS_CNT  + Q_STRIDE * m));
    assign q_push[m]   = wr_req & hit_msg[m];
    assign q_pop[m]    = rd_req & hit_msg[m];

    mbox_queue #(.DW(DW), .DEPTH(DEPTH)) u_q (
      .clk   (clk),
      .rst_n (rst_core_n),
      .push  (q_push[m]),
      .wdata (bus_wdata),
      .pop   (q_pop[m]),
      .head  (q_head[m]),
      .count (q_cnt[m]),
      .full  (q_full[m]),
      .empty (q_empty[m]),
      .act   (q_act[m])
    );

    // Bit 2m: new message; bit 2m+1: room available.
    assign evt[2*m]   = q_act[m].push_ok | ~q_empty[m];
    assign evt[2*m+1] = q_act[m].pop_ok  | ~q_full[m];
  end

  logic [NB-1:0] u_stat [NU];
  logic [NB-1:0] u_en   [NU];

  for (genvar u = 0; u < NU; u++) begin : g_user
    assign hit_stat[u] = (bus_addr == AW'(OFS_USR_STAT + U_STRIDE * u));
    assign hit_eset[u] = (bus_addr == AW'(OFS_USR_ESET + U_STRIDE * u));
    assign hit_eclr[u] = (bus_addr == AW'(OFS_USR_ECLR + U_STRIDE * u));

    mbox_user_irq #(.NB(NB)) u_usr (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .evt     (evt),
      .stat_we (wr_req & hit_stat[u]),
      .eset_we (wr_req & hit_eset[u]),
      .eclr_we (wr_req & hit_eclr[u]),
      .wdata   (bus_wdata[NB-1:0]),
      .status  (u_stat[u]),
      .enable  (u_en[u]),
      .irq     (irq[u])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_req) begin
      if (hit_id) bus_rdata = DW'(ID);
      for (int m = 0; m < NQ; m++) begin
        if (hit_msg[m])  bus_rdata = q_head[m];
        if (hit_full[m]) bus_rdata = DW'(q_full[m]);
        if (hit_cnt[m])  bus_rdata = DW'(q_cnt[m]);
      end
      for (int u = 0; u < NU; u++) begin
        if (hit_stat[u])               bus_rdata = DW'(u_stat[u]);
        if (hit_eset[u] | hit_eclr[u]) bus_rdata = DW'(u_en[u]);
      end
    end
  end

  // R12: while held in reset, no interrupt is raised.
  a_r12_quiet_in_reset: assert property (@(posedge clk)
    !rst_core_n |-> (irq == '0));

  // R2: a single bus touches at most one queue per cycle.
  a_r2_one_queue_action: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0(q_push | q_pop));
endmodule

// File: tb/sim_mbox_hub.sv
module sim_mbox_hub;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 50;
  localparam logic [1:0] OW = 2'd0;  // write
  localparam logic [1:0] OR = 2'd1;  // read and compare
  localparam logic [31:0] IDV = 32'h4D42_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_hub u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // {req, op, addr, wdata, expected}
  localparam logic [81:0] VEC [NVEC] = '{
    {4'd1,  OR, 12'h000, 32'h0,        IDV},          // R1
    {4'd1,  OW, 12'h000, 32'hFFFFFFFF, 32'h0},        // R1 write ignored
    {4'd1,  OR, 12'h000, 32'h0,        IDV},          // R1
    {4'd8,  OR, 12'h104, 32'h0,        32'hAA},       // R8 room everywhere
    {4'd4,  OR, 12'h0C0, 32'h0,        32'h0},        // R4
    {4'd2,  OW, 12'h040, 32'h11111111, 32'h0},        // R2
    {4'd2,  OW, 12'h040, 32'h22222222, 32'h0},        // R2
    {4'd4,  OR, 12'h0C0, 32'h0,        32'h2},        // R4
    {4'd6,  OR, 12'h104, 32'h0,        32'hAB},       // R6 bit 0
    {4'd6,  OR, 12'h114, 32'h0,        32'hAB},       // R6 user 1
    {4'd2,  OR, 12'h040, 32'h0,        32'h11111111}, // R2 oldest first
    {4'd4,  OR, 12'h0C0, 32'h0,        32'h1},        // R4
    {4'd9,  OW, 12'h104, 32'h1,        32'h0},        // R9
    {4'd7,  OR, 12'h104, 32'h0,        32'hAA},       // R7 gap cycle
    {4'd7,  OR, 12'h104, 32'h0,        32'hAB},       // R7 re-armed
    {4'd2,  OR, 12'h040, 32'h0,        32'h22222222}, // R2
    {4'd5,  OR, 12'h040, 32'h0,        32'h0},        // R5 empty read
    {4'd5,  OR, 12'h0C0, 32'h0,        32'h0},        // R5
    {4'd9,  OW, 12'h104, 32'h1,        32'h0},        // R9
    {4'd7,  OR, 12'h104, 32'h0,        32'hAA},       // R7 empty stays 0
    {4'd7,  OR, 12'h104, 32'h0,        32'hAA},       // R7
    {4'd9,  OW, 12'h104, 32'hFF,       32'h0},        // R9 all
    {4'd9,  OR, 12'h104, 32'h0,        32'h00},       // R9
    {4'd8,  OR, 12'h104, 32'h0,        32'hAA},       // R8 re-armed
    {4'd9,  OR, 12'h114, 32'h0,        32'hAB},       // R9 other user kept
    {4'd2,  OW, 12'h048, 32'hA0000000, 32'h0},        // R2
    {4'd2,  OW, 12'h048, 32'hA0000001, 32'h0},
    {4'd2,  OW, 12'h048, 32'hA0000002, 32'h0},
    {4'd2,  OW, 12'h048, 32'hA0000003, 32'h0},
    {4'd3,  OR, 12'h088, 32'h0,        32'h1},        // R3 full
    {4'd4,  OR, 12'h0C8, 32'h0,        32'h4},        // R4
    {4'd5,  OW, 12'h048, 32'hDEADBEEF, 32'h0},        // R5 dropped
    {4'd5,  OR, 12'h0C8, 32'h0,        32'h4},        // R5
    {4'd8,  OW, 12'h104, 32'h20,       32'h0},        // R8 clear room bit
    {4'd8,  OR, 12'h104, 32'h0,        32'h9A},       // R8
    {4'd8,  OR, 12'h104, 32'h0,        32'h9A},       // R8 full keeps 0
    {4'd5,  OR, 12'h048, 32'h0,        32'hA0000000}, // R5 contents intact
    {4'd8,  OR, 12'h104, 32'h0,        32'hBA},       // R8 pop relieves
    {4'd3,  OR, 12'h088, 32'h0,        32'h0},        // R3
    {4'd2,  OR, 12'h048, 32'h0,        32'hA0000001}, // R2
    {4'd2,  OR, 12'h048, 32'h0,        32'hA0000002}, // R2
    {4'd5,  OR, 12'h048, 32'h0,        32'hA0000003}, // R5 not DEADBEEF
    {4'd4,  OR, 12'h0C8, 32'h0,        32'h0},        // R4
    {4'd10, OW, 12'h108, 32'h10,       32'h0},        // R10
    {4'd10, OW, 12'h108, 32'h01,       32'h0},        // R10
    {4'd10, OR, 12'h108, 32'h0,        32'h11},       // R10 OR-in
    {4'd10, OR, 12'h10C, 32'h0,        32'h11},       // R10
    {4'd10, OW, 12'h10C, 32'h10,       32'h0},        // R10
    {4'd10, OR, 12'h108, 32'h0,        32'h01},       // R10
    {4'd10, OR, 12'h118, 32'h0,        32'h0}         // R10 user 1 apart
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic [1:0] op, input logic [11:0] a,
                        input logic [31:0] d, input logic [31:0] exp, input int req);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = (op == OW); bus_addr = a[8:0]; bus_wdata = d;
    #1;
    if (op == OR) check(req, bus_rdata, exp);
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R0 watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    // R12: state while reset is held
    repeat (3) @(posedge clk);
    bus_op(OR, 12'h104, 0, 32'h0, 12);
    bus_op(OR, 12'h0C0, 0, 32'h0, 12);
    check(12, {30'h0, irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(posedge clk);

    for (int i = 0; i < NVEC; i++)
      bus_op(VEC[i][77:76], VEC[i][75:64], VEC[i][63:32], VEC[i][31:0], int'(VEC[i][81:78]));

    // R11: user0 enables = bit0 only, queue 0 empty -> no interrupt
    check(11, {30'h0, irq}, 32'h0);
    bus_op(OW, 12'h040, 32'h55, 0, 11);
    check(11, {30'h0, irq}, 32'h1);           // R11 user0 only
    bus_op(OW, 12'h118, 32'h02, 0, 11);
    check(11, {30'h0, irq}, 32'h3);           // R11 user1 on not-full
    bus_op(OW, 12'h104, 32'h01, 0, 7);
    check(7, {30'h0, irq}, 32'h2);            // R7 gap cycle drops irq0
    @(posedge clk); #1;
    check(7, {30'h0, irq}, 32'h3);            // R7 re-armed
    bus_op(OW, 12'h10C, 32'h01, 0, 11);
    check(11, {30'h0, irq}, 32'h2);           // R11 masked

    // R12: reset in the middle of traffic
    @(negedge clk); rst_n = 1'b0;
    bus_op(OR, 12'h0C0, 0, 32'h0, 12);
    bus_op(OR, 12'h118, 0, 32'h0, 12);
    check(12, {30'h0, irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    bus_op(OR, 12'h040, 0, 32'h0, 12);
    bus_op(OR, 12'h104, 0, 32'hAA, 12);

    done = 1'b1;
    finish_run();
  end
endmodule